// File: doc/BRIEF.md
# Cursor Overlay Pixel Path

This block sits between a raster timing source and a display output. It takes one framebuffer pixel per cycle: an 8-bit colour index, its x/y coordinate and its sync and blanking flags. It returns a 24-bit RGB value two cycles later. Each pixel is tested against a 64x64 hardware cursor window. Inside the window, a 2-bit cursor code is read from a pattern store. A zero code lets the framebuffer colour through. A non-zero code replaces the pixel with one of three cursor colours.

The block also produces the framebuffer byte address for the external memory fetch. That address restarts at a programmable top-of-screen offset and steps once per accepted pixel. Control inputs can hide the cursor or black out the whole picture. The colour table, the three cursor colours and the pattern are loaded through one write port driven by a register block.

Top module: `curovl_pixpath`

## Requirements
- R1: After reset, `out_valid`, `out_hsync`, `out_vsync`, `out_blank` and `out_rgb` are 0 and `vram_addr` is 0.
- R2: `out_valid`, `out_hsync`, `out_vsync` and `out_blank` repeat `in_valid`, `in_hsync`, `in_vsync` and `in_blank` exactly two clock cycles later.
- R3: The cursor origin is taken from `cfg_cursor_pos`: x from bits 23:12 and y from bits 11:0. A pixel lies in the cursor window when cx <= x < cx+64 and cy <= y < cy+64. The compares are carried out wide enough that a window near coordinate 4095 neither wraps to low coordinates nor loses its far part.
- R4: For a pixel in the window, with dx = x-cx and dy = y-cy, the pattern word is number dy*8 + dx/8. The cursor code is bits [2*(dx mod 8) +: 2] of that word.
- R5: Code 0 shows colour table entry `in_index`. Codes 1, 2 and 3 show cursor colours 0, 1 and 2.
- R6: While `cfg_cursor_off` is 1, every pixel shows colour table entry `in_index`.
- R7: A pixel accepted while `cfg_force_blank` is 1 comes out with `out_rgb` = 0.
- R8: A pixel accepted with `in_blank` = 1 comes out with `out_rgb` = 0. While `out_valid` is 0, `out_rgb` is 0.
- R9: A cycle with `frame_start` = 1 loads `vram_addr` with `cfg_top_offset`. This holds even if `in_valid` is also 1. Otherwise each cycle with `in_valid` = 1 adds one to `vram_addr`, and other cycles hold it. The new value shows on the port after the clock edge.
- R10: Write port encoding, one write per cycle with `wr_en` = 1:
  - `wr_sel` = 0 writes colour table entry `wr_addr[7:0]` with `wr_data` as {R,G,B}.
  - `wr_sel` = 1 writes cursor colour `wr_addr[1:0]` (0 to 2; 3 is dropped).
  - `wr_sel` = 2 writes pattern word `wr_addr[8:0]` with `wr_data[15:0]`.
  - `wr_sel` = 3 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_force_blank | input | 1 | Black out every pixel |
| cfg_cursor_off | input | 1 | Hide the cursor |
| cfg_cursor_pos | input | 24 | Cursor origin, x in 23:12, y in 11:0 |
| cfg_top_offset | input | 23 | Framebuffer byte address of the first pixel |
| wr_en | input | 1 | Table write strobe |
| wr_sel | input | 2 | Write target |
| wr_addr | input | 9 | Write entry number |
| wr_data | input | 24 | Write data |
| frame_start | input | 1 | Restart the fetch address |
| in_valid | input | 1 | Pixel present this cycle |
| in_x | input | 12 | Pixel column |
| in_y | input | 12 | Pixel row |
| in_index | input | 8 | Framebuffer colour index |
| in_hsync | input | 1 | Horizontal sync in |
| in_vsync | input | 1 | Vertical sync in |
| in_blank | input | 1 | Blanking interval in |
| vram_addr | output | 23 | Framebuffer byte address for the fetch |
| out_valid | output | 1 | Output pixel present |
| out_hsync | output | 1 | Horizontal sync out |
| out_vsync | output | 1 | Vertical sync out |
| out_blank | output | 1 | Blanking interval out |
| out_rgb | output | 24 | Pixel colour {R,G,B} |

## Verification
The bench builds the block with its default parameters: 12-bit coordinates, 8-bit indices, a 64x64 cursor and 16-bit pattern words. At that size the whole pattern store (512 words, all 4096 cursor cells) and the whole 256-entry colour table fit in a sweep of a few thousand cycles, so every word and every code position is compared against arithmetic expectations. The default coordinate width also lets a cursor be placed at 4090/4093, where a 12-bit compare would wrap, and the bench checks pixels on both sides of that edge.

// File: rtl/curovl_pkg.sv
package curovl_pkg;

    // Target of a table write, decoded from wr_sel.
    typedef enum logic [1:0] {
        WT_COLOR   = 2'd0,
        WT_CURSOR  = 2'd1,
        WT_PATTERN = 2'd2,
        WT_NONE    = 2'd3
    } wr_tgt_e;

    // Cursor cell encoding: bits per cell and the number of cursor colours.
    localparam int CODE_W      = 2;
    localparam int NUM_CUR_COL = (1 << CODE_W) - 1;

endpackage

// File: rtl/curovl_sync_ram.sv
// Single write port, single synchronous read port; the read returns the
// contents before a same-cycle write to the same entry.
module curovl_sync_ram #(
    parameter int DEPTH = 256,
    parameter int WIDTH = 24,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [WIDTH-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
        rdata_q <= mem_q[raddr];
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/curovl_hit.sv
// Cursor window test and pattern cell addressing, purely combinational.
module curovl_hit #(
    parameter int COORD_W = 12,
    parameter int CUR_DIM = 64,
    parameter int PAT_W   = 16,
    localparam int PIX_PER_WORD = PAT_W / curovl_pkg::CODE_W,
    localparam int SEL_W   = $clog2(PIX_PER_WORD),
    localparam int CUR_LOG = $clog2(CUR_DIM),
    localparam int PAT_AW  = 2 * CUR_LOG - SEL_W
) (
    input  logic [COORD_W-1:0]   x,
    input  logic [COORD_W-1:0]   y,
    input  logic [2*COORD_W-1:0] pos,
    input  logic                 cursor_off,
    output logic                 hit,
    output logic [PAT_AW-1:0]    word_idx,
    output logic [SEL_W-1:0]     cell_sel
);

    localparam int WW = COORD_W + 1;

    logic [WW-1:0] cx_w, cy_w, x_w, y_w, dx, dy;
    logic          in_x, in_y;

    always_comb begin
        cx_w = {1'b0, pos[2*COORD_W-1:COORD_W]};
        cy_w = {1'b0, pos[COORD_W-1:0]};
        x_w  = {1'b0, x};
        y_w  = {1'b0, y};
        dx   = x_w - cx_w;
        dy   = y_w - cy_w;
        // Widened: the difference is only trusted when x >= cx, so an
        // origin near the top coordinate never wraps around to zero.
        in_x = (x_w >= cx_w) && (dx < WW'(CUR_DIM));
        in_y = (y_w >= cy_w) && (dy < WW'(CUR_DIM));
        hit  = in_x && in_y && !cursor_off;
        word_idx = {dy[CUR_LOG-1:0], dx[CUR_LOG-1:SEL_W]};
        cell_sel = dx[SEL_W-1:0];
    end

endmodule

// File: rtl/curovl_scan_addr.sv
// Framebuffer fetch address: reload on frame start, step per pixel.
module curovl_scan_addr #(
    parameter int VADDR_W = 23
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic               advance,
    input  logic [VADDR_W-1:0] base,
    output logic [VADDR_W-1:0] addr
);

    logic [VADDR_W-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (restart) begin
            addr_d = base;
        end else if (advance) begin
            addr_d = addr_q + VADDR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_d;
        end
    end

    assign addr = addr_q;

endmodule

// File: rtl/curovl_pixpath.sv
module curovl_pixpath #(
    parameter int COORD_W = 12,
    parameter int IDX_W   = 8,
    parameter int CH_W    = 8,
    parameter int CUR_DIM = 64,
    parameter int PAT_W   = 16,
    parameter int VADDR_W = 23,
    localparam int COLOR_W      = 3 * CH_W,
    localparam int PIX_PER_WORD = PAT_W / curovl_pkg::CODE_W,
    localparam int SEL_W        = $clog2(PIX_PER_WORD),
    localparam int PAT_DEPTH    = CUR_DIM * CUR_DIM / PIX_PER_WORD,
    localparam int PAT_AW       = $clog2(PAT_DEPTH),
    localparam int PAL_DEPTH    = 1 << IDX_W,
    localparam int WR_AW        = (PAT_AW > IDX_W) ? PAT_AW : IDX_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_force_blank,
    input  logic                 cfg_cursor_off,
    input  logic [2*COORD_W-1:0] cfg_cursor_pos,
    input  logic [VADDR_W-1:0]   cfg_top_offset,
    input  logic                 wr_en,
    input  logic [1:0]           wr_sel,
    input  logic [WR_AW-1:0]     wr_addr,
    input  logic [COLOR_W-1:0]   wr_data,
    input  logic                 frame_start,
    input  logic                 in_valid,
    input  logic [COORD_W-1:0]   in_x,
    input  logic [COORD_W-1:0]   in_y,
    input  logic [IDX_W-1:0]     in_index,
    input  logic                 in_hsync,
    input  logic                 in_vsync,
    input  logic                 in_blank,
    output logic [VADDR_W-1:0]   vram_addr,
    output logic                 out_valid,
    output logic                 out_hsync,
    output logic                 out_vsync,
    output logic                 out_blank,
    output logic [COLOR_W-1:0]   out_rgb
);
    import curovl_pkg::*;

    localparam int CSEL_W = $clog2(NUM_CUR_COL + 1);

    typedef struct packed {
        // stage 1: tables being read, side data aligned with them
        logic                                   s1_valid;
        logic                                   s1_hsync;
        logic                                   s1_vsync;
        logic                                   s1_blank;
        logic                                   s1_black;
        logic                                   s1_hit;
        logic [SEL_W-1:0]                       s1_sel;
        // stage 2: output register
        logic                                   o_valid;
        logic                                   o_hsync;
        logic                                   o_vsync;
        logic                                   o_blank;
        logic [COLOR_W-1:0]                     o_rgb;
        // cursor colours, small enough to keep in flops
        logic [NUM_CUR_COL-1:0][COLOR_W-1:0]    cpal;
    } state_t;

    state_t st_d, st_q;

    wr_tgt_e             tgt;
    logic                col_we, pat_we;
    logic                hit;
    logic [PAT_AW-1:0]   word_idx;
    logic [SEL_W-1:0]    cell_sel;
    logic [COLOR_W-1:0]  col_rd;
    logic [PAT_W-1:0]    pat_rd;
    logic [CODE_W-1:0]   code;
    logic [CSEL_W-1:0]   cur_ent;
    logic [COLOR_W-1:0]  mix_rgb;

    assign tgt    = wr_tgt_e'(wr_sel);
    assign col_we = wr_en && (tgt == WT_COLOR);
    assign pat_we = wr_en && (tgt == WT_PATTERN);

    curovl_hit #(
        .COORD_W (COORD_W),
        .CUR_DIM (CUR_DIM),
        .PAT_W   (PAT_W)
    ) u_hit (
        .x          (in_x),
        .y          (in_y),
        .pos        (cfg_cursor_pos),
        .cursor_off (cfg_cursor_off),
        .hit        (hit),
        .word_idx   (word_idx),
        .cell_sel   (cell_sel)
    );

    curovl_sync_ram #(
        .DEPTH (PAL_DEPTH),
        .WIDTH (COLOR_W)
    ) u_color_tab (
        .clk   (clk),
        .we    (col_we),
        .waddr (wr_addr[IDX_W-1:0]),
        .wdata (wr_data),
        .raddr (in_index),
        .rdata (col_rd)
    );

    curovl_sync_ram #(
        .DEPTH (PAT_DEPTH),
        .WIDTH (PAT_W)
    ) u_pattern (
        .clk   (clk),
        .we    (pat_we),
        .waddr (wr_addr[PAT_AW-1:0]),
        .wdata (wr_data[PAT_W-1:0]),
        .raddr (word_idx),
        .rdata (pat_rd)
    );

    curovl_scan_addr #(
        .VADDR_W (VADDR_W)
    ) u_scan (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (frame_start),
        .advance (in_valid),
        .base    (cfg_top_offset),
        .addr    (vram_addr)
    );

    always_comb begin
        st_d = st_q;

        // stage 1 capture
        st_d.s1_valid = in_valid;
        st_d.s1_hsync = in_hsync;
        st_d.s1_vsync = in_vsync;
        st_d.s1_blank = in_blank;
        st_d.s1_black = cfg_force_blank | in_blank;
        st_d.s1_hit   = hit;
        st_d.s1_sel   = cell_sel;

        // stage 2: code extraction and colour choice
        code    = pat_rd[{st_q.s1_sel, 1'b0} +: CODE_W];
        cur_ent = CSEL_W'(code) - CSEL_W'(1);
        if (st_q.s1_hit && (code != '0)) begin
            mix_rgb = st_q.cpal[cur_ent];
        end else begin
            mix_rgb = col_rd;
        end

        st_d.o_valid = st_q.s1_valid;
        st_d.o_hsync = st_q.s1_hsync;
        st_d.o_vsync = st_q.s1_vsync;
        st_d.o_blank = st_q.s1_blank;
        st_d.o_rgb   = (st_q.s1_valid && !st_q.s1_black) ? mix_rgb : '0;

        // cursor colour writes; entry numbers past the last are dropped
        if (wr_en && (tgt == WT_CURSOR)
                && (int'(wr_addr[CSEL_W-1:0]) < NUM_CUR_COL)) begin
            st_d.cpal[wr_addr[CSEL_W-1:0]] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.o_valid;
    assign out_hsync = st_q.o_hsync;
    assign out_vsync = st_q.o_vsync;
    assign out_blank = st_q.o_blank;
    assign out_rgb   = st_q.o_rgb;

endmodule

// File: rtl/curovl_pixpath_chk.sv
module curovl_pixpath_chk #(
    parameter int COLOR_W = 24,
    parameter int VADDR_W = 23
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_force_blank,
    input logic [VADDR_W-1:0] cfg_top_offset,
    input logic               frame_start,
    input logic               in_valid,
    input logic               in_hsync,
    input logic               in_vsync,
    input logic               in_blank,
    input logic [VADDR_W-1:0] vram_addr,
    input logic               out_valid,
    input logic               out_hsync,
    input logic               out_vsync,
    input logic               out_blank,
    input logic [COLOR_W-1:0] out_rgb
);

    // Cycles since reset, saturating at 2, so two-deep $past is trusted.
    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (age_q != 2'd2) begin
            age_q <= age_q + 2'd1;
        end
    end

    p_lat_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> (out_valid == $past(in_valid, 2)));

    p_lat_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> (out_hsync == $past(in_hsync, 2)
                          && out_vsync == $past(in_vsync, 2)
                          && out_blank == $past(in_blank, 2)));

    p_force_black_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2 && $past(cfg_force_blank, 2)) |-> (out_rgb == '0));

    p_idle_black_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_rgb == '0));

    p_addr_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (vram_addr == $past(cfg_top_offset)));

    p_addr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !frame_start) |=> (vram_addr == $past(vram_addr) + VADDR_W'(1)));

    p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !frame_start) |=> $stable(vram_addr));

endmodule

bind curovl_pixpath curovl_pixpath_chk #(
    .COLOR_W (COLOR_W),
    .VADDR_W (VADDR_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_force_blank (cfg_force_blank),
    .cfg_top_offset  (cfg_top_offset),
    .frame_start     (frame_start),
    .in_valid        (in_valid),
    .in_hsync        (in_hsync),
    .in_vsync        (in_vsync),
    .in_blank        (in_blank),
    .vram_addr       (vram_addr),
    .out_valid       (out_valid),
    .out_hsync       (out_hsync),
    .out_vsync       (out_vsync),
    .out_blank       (out_blank),
    .out_rgb         (out_rgb)
);

// File: tb/curovl_pixpath_tb.sv
module curovl_pixpath_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_force_blank = 1'b0;
    logic        cfg_cursor_off = 1'b0;
    logic [23:0] cfg_cursor_pos = '0;
    logic [22:0] cfg_top_offset = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd3;
    logic [8:0]  wr_addr = '0;
    logic [23:0] wr_data = '0;
    logic        frame_start = 1'b0;
    logic        in_valid = 1'b0;
    logic [11:0] in_x = '0;
    logic [11:0] in_y = '0;
    logic [7:0]  in_index = '0;
    logic        in_hsync = 1'b0;
    logic        in_vsync = 1'b0;
    logic        in_blank = 1'b0;
    logic [22:0] vram_addr;
    logic        out_valid, out_hsync, out_vsync, out_blank;
    logic [23:0] out_rgb;

    always #5 clk = ~clk;

    curovl_pixpath u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_force_blank (cfg_force_blank),
        .cfg_cursor_off  (cfg_cursor_off),
        .cfg_cursor_pos  (cfg_cursor_pos),
        .cfg_top_offset  (cfg_top_offset),
        .wr_en           (wr_en),
        .wr_sel          (wr_sel),
        .wr_addr         (wr_addr),
        .wr_data         (wr_data),
        .frame_start     (frame_start),
        .in_valid        (in_valid),
        .in_x            (in_x),
        .in_y            (in_y),
        .in_index        (in_index),
        .in_hsync        (in_hsync),
        .in_vsync        (in_vsync),
        .in_blank        (in_blank),
        .vram_addr       (vram_addr),
        .out_valid       (out_valid),
        .out_hsync       (out_hsync),
        .out_vsync       (out_vsync),
        .out_blank       (out_blank),
        .out_rgb         (out_rgb)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // Bench copy of the controls, used for expectations.
    int cx = 0, cy = 0;
    bit m_off = 1'b0, m_fb = 1'b0;

    typedef struct {
        bit          v, hs, vs, bl;
        logic [23:0] rgb;
        string       tag;
    } exp_t;

    exp_t q1 = '{1'b0, 1'b0, 1'b0, 1'b0, 24'h0, "R1"};
    exp_t q2 = '{1'b0, 1'b0, 1'b0, 1'b0, 24'h0, "R1"};

    function automatic logic [23:0] col_of(int i);
        logic [7:0] b = i[7:0];
        return {b, ~b, b ^ 8'h5A};
    endfunction

    function automatic logic [15:0] pat_of(int w);
        return 16'(w * 40503 + 4660);
    endfunction

    function automatic logic [23:0] cur_of(int k);
        case (k)
            0:       return 24'hFF1020;
            1:       return 24'h10FF30;
            default: return 24'h2030FF;
        endcase
    endfunction

    function automatic logic [23:0] expect_rgb(int x, int y, int idx, bit bl,
                                               output string tag);
        int dx, dy, code;
        logic [15:0] w;
        if (m_fb) begin
            tag = "R7";
            return 24'h0;
        end
        if (bl) begin
            tag = "R8";
            return 24'h0;
        end
        if (m_off) begin
            tag = "R6 R10";
            return col_of(idx);
        end
        if (x >= cx && x < cx + 64 && y >= cy && y < cy + 64) begin
            dx = x - cx;
            dy = y - cy;
            w = pat_of(dy * 8 + dx / 8);
            code = int'((w >> ((dx % 8) * 2)) & 16'h3);
            if (code != 0) begin
                tag = "R3 R4 R5 R10";
                return cur_of(code - 1);
            end
            tag = "R4 R5";
            return col_of(idx);
        end
        tag = "R3 R10";
        return col_of(idx);
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: compare outputs for the pixel driven two cycles earlier,
    // then drive the next input.
    task automatic step(bit v, int x, int y, int idx, bit bl, bit fs);
        exp_t e;
        string t;
        @(negedge clk);
        check({q2.tag, " R2"},
              64'({out_valid, out_hsync, out_vsync, out_blank, out_rgb}),
              64'({q2.v, q2.hs, q2.vs, q2.bl, q2.rgb}));
        q2 = q1;
        if (v) begin
            e.v = 1'b1;
            e.hs = x[0];
            e.vs = y[0];
            e.bl = bl;
            e.rgb = expect_rgb(x, y, idx, bl, t);
            e.tag = t;
        end else begin
            e = '{1'b0, 1'b0, 1'b0, 1'b0, 24'h0, "R8"};
        end
        q1 = e;
        frame_start = fs;
        in_valid = v;
        in_x = 12'(x);
        in_y = 12'(y);
        in_index = 8'(idx);
        in_hsync = v ? x[0] : 1'b0;
        in_vsync = v ? y[0] : 1'b0;
        in_blank = v ? bl : 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(1'b0, 0, 0, 0, 1'b0, 1'b0);
    endtask

    task automatic set_ctl(int x, int y, bit off, bit fb);
        idle(2);
        cx = x;
        cy = y;
        m_off = off;
        m_fb = fb;
        cfg_cursor_pos = {12'(x), 12'(y)};
        cfg_cursor_off = off;
        cfg_force_blank = fb;
    endtask

    task automatic wr(int sel, int a, logic [23:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_sel = 2'(sel);
        wr_addr = 9'(a);
        wr_data = d;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", 64'({out_valid, out_hsync, out_vsync, out_blank, out_rgb, vram_addr}), 64'h0);

        // R10: load all tables through the write port
        for (int i = 0; i < 256; i++) wr(0, i, col_of(i));
        for (int i = 0; i < 512; i++) wr(2, i, {8'h00, pat_of(i)});
        for (int k = 0; k < 3; k++) wr(1, k, cur_of(k));
        wr(1, 3, 24'hABCDEF);      // entry 3 dropped
        wr(3, 5, 24'h123456);      // no target
        @(negedge clk);
        wr_en = 1'b0;

        // R9: fetch address reload and stepping
        cfg_top_offset = 23'h012345;
        set_ctl(0, 0, 1'b1, 1'b0);
        step(1'b0, 0, 0, 0, 1'b0, 1'b1);
        @(posedge clk);
        #1 check("R9 load", 64'(vram_addr), 64'h012345);
        for (int i = 0; i < 5; i++) step(1'b1, i, 0, i, 1'b0, 1'b0);
        @(posedge clk);
        #1 check("R9 step", 64'(vram_addr), 64'h01234A);
        idle(1);
        @(posedge clk);
        #1 check("R9 hold", 64'(vram_addr), 64'h01234A);
        step(1'b1, 0, 0, 0, 1'b0, 1'b1);
        @(posedge clk);
        #1 check("R9 load wins", 64'(vram_addr), 64'h012345);

        // R6: cursor hidden, every colour table entry shown
        set_ctl(0, 0, 1'b1, 1'b0);
        for (int y = 0; y < 16; y++)
            for (int x = 0; x < 16; x++) step(1'b1, x, y, y * 16 + x, 1'b0, 1'b0);

        // R4 R5: cursor at origin, whole pattern store swept
        set_ctl(0, 0, 1'b0, 1'b0);
        for (int y = 0; y < 64; y++)
            for (int x = 0; x < 64; x++) step(1'b1, x, y, (x * 3 + y * 7) & 255, 1'b0, 1'b0);

        // R3 R8: cursor inside the frame, window edges crossed, blanked tail
        set_ctl(10, 5, 1'b0, 1'b0);
        for (int y = 0; y < 75; y++)
            for (int x = 0; x < 80; x++) step(1'b1, x, y, (x * 3 + y * 7) & 255, x >= 77, 1'b0);

        // R3: cursor near the top coordinate, no wrap either way
        set_ctl(4090, 4093, 1'b0, 1'b0);
        for (int y = 4088; y < 4096; y++)
            for (int x = 4084; x < 4096; x++) step(1'b1, x, y, (x + y) & 255, 1'b0, 1'b0);
        for (int y = 0; y < 5; y++)
            for (int x = 0; x < 8; x++) step(1'b1, x, y, (x * 5 + y) & 255, 1'b0, 1'b0);

        // R7: forced blank inside the cursor window
        set_ctl(0, 0, 1'b0, 1'b1);
        for (int x = 0; x < 32; x++) step(1'b1, x, 1, x, 1'b0, 1'b0);

        idle(3);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule